// File: doc/BRIEF.md
# Triple-Pulse Timing Generator

The block turns one trigger event into a short train of up to three output pulses. Each pulse slot has its own start offset and its own length. A common offset is added to every slot, and a common extension is added to the length of every enabled slot. A mode input sets how many slots take part. A polarity input sets which output level counts as idle.

A trigger selector upstream drives the start line. The block acts on a low-to-high transition of that line. On the clock edge that accepts the transition, it captures the mode and all timing values, raises busy and starts a cycle counter. While busy is high, further triggers are ignored. The pulse line is high in every cycle that falls inside any enabled slot's window.

Top module: `tpg_top`

## Requirements
- R1: While rst_ni is low and after it is released, busy_o is 0 and pulse_o equals pol_i.
- R2: A rising edge of start_i is accepted at the clock edge where start_i is 1 and was 0 at the previous edge, provided busy_o is 0 and at least one slot is enabled. The cycle after that edge is cycle t=0 of the sequence and busy_o is 1 there. With group delay 0, slot delay 0 and width 1, pulse_o is active in t=0 only.
- R3: Slot k is active for t in [gdly+dly_k, gdly+dly_k+wid_k+gwid). The active level of pulse_o is the OR of all active slots. Slot k sits at bits [24k+23:24k] of dly_i and wid_i. For example, delays 5/15/30 with widths 5/6/7 give three separate pulses at those offsets.
- R4: The number of enabled slots follows mode_i: 1 enables slot 0; 2 enables slots 0 and 1; 3 enables all three. Modes 0 and 4 to 7 enable none, so start_i is ignored and busy_o stays 0.
- R5: An enabled slot whose own width is 0 produces no pulse. If no enabled slot has a nonzero width, start_i is ignored.
- R6: A rising edge of start_i while busy_o is 1 is ignored, including in the last busy cycle; the running sequence keeps its timing.
- R7: busy_o stays 1 exactly for t < the largest end offset among the pulsing slots, then returns to 0.
- R8: pulse_o is the active level XOR pol_i: with pol_i=0 it idles low and pulses high, and with pol_i=1 the output is inverted. pol_i acts immediately.
- R9: mode_i, the delays and the widths are sampled only at acceptance. Changing them during a sequence does not alter it.
- R10: Holding start_i high does not start a new sequence; only a fresh 0-to-1 transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Trigger line, acted on at its rising edge |
| mode_i | input | 3 | Number of enabled slots (1..3), other values disable |
| pol_i | input | 1 | Output sense, 1 inverts |
| gdly_i | input | DW | Common offset added to every slot delay |
| gwid_i | input | DW | Common extension added to every pulsing slot width |
| dly_i | input | 3*DW | Per-slot delays, slot k at bits [DW*k +: DW] |
| wid_i | input | 3*DW | Per-slot widths, slot k at bits [DW*k +: DW], 0 suppresses the slot |
| pulse_o | output | 1 | Pulse output |
| busy_o | output | 1 | High from acceptance until the last pulse ends |

## Verification
The assertions assume that start_i and the configuration inputs are synchronous and settle between clock edges. The bench meets this by driving every input only at the falling clock edge. Because the configuration is captured at acceptance, the bench changes it freely while a sequence runs, and the assertions that the captured copy holds still apply. The random phase keeps the delays and widths small so that many sequences fit in the run, while the directed cases use the full pattern with offsets 5, 15 and 30.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int NSLOT = 3;

  // slots enabled by a mode code; reserved codes enable none
  function automatic logic [1:0] slot_count(input logic [2:0] mode);
    case (mode)
      3'd1:    return 2'd1;
      3'd2:    return 2'd2;
      3'd3:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/tpg_slot.sv
module tpg_slot #(
  parameter int DW = 24,
  parameter int CW = DW + 2
) (
  input  logic [CW-1:0] cnt_i,
  input  logic          en_i,
  input  logic [DW-1:0] dly_i,
  input  logic [DW-1:0] wid_i,
  input  logic [DW-1:0] gdly_i,
  input  logic [DW-1:0] gwid_i,
  output logic          hit_o,
  output logic [CW-1:0] end_o
);
  logic [CW-1:0] t_start, t_end;
  logic          live;

  always_comb begin
    live    = en_i && (wid_i != '0);
    t_start = CW'(gdly_i) + CW'(dly_i);
    t_end   = t_start + CW'(wid_i) + CW'(gwid_i);
    hit_o   = live && (cnt_i >= t_start) && (cnt_i < t_end);
    end_o   = live ? t_end : '0;
  end
endmodule

// File: rtl/tpg_seq.sv
module tpg_seq #(
  parameter int CW = 26
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          arm_i,
  input  logic [CW-1:0] last_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic [CW-1:0] cnt_o
);
  logic          start_q, busy_q;
  logic [CW-1:0] cnt_q;

  assign accept_o = start_i && !start_q && arm_i && !busy_q;
  assign busy_o   = busy_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      start_q <= start_i;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == last_i - 1'b1) busy_q <= 1'b0;
        else                        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !start_q && arm_i && !busy_q) |=> (busy_q && cnt_q == '0));

  // R6
  no_retrigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));

  // R7
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(cnt_q) + 1'b1 == $past(last_i)));

  // R10
  level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && start_q && start_i) |=> !busy_q);
endmodule

// File: rtl/tpg_top.sv
module tpg_top
  import tpg_pkg::*;
#(
  parameter int DW = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic              pol_i,
  input  logic [DW-1:0]     gdly_i,
  input  logic [DW-1:0]     gwid_i,
  input  logic [NSLOT*DW-1:0] dly_i,
  input  logic [NSLOT*DW-1:0] wid_i,
  output logic              pulse_o,
  output logic              busy_o
);
  localparam int CW = DW + 2;

  logic [1:0]          n_q;
  logic [DW-1:0]       gdly_q, gwid_q;
  logic [NSLOT*DW-1:0] dly_q, wid_q;

  logic [NSLOT-1:0] arm_bits, hit;
  logic [CW-1:0]    ends [NSLOT];
  logic [CW-1:0]    last, cnt;
  logic             arm, accept, busy;

  genvar k;
  generate
    for (k = 0; k < NSLOT; k++) begin : g_slot
      assign arm_bits[k] = (k < int'(slot_count(mode_i))) && (wid_i[DW*k +: DW] != '0);

      tpg_slot #(.DW(DW), .CW(CW)) u_slot (
        .cnt_i (cnt),
        .en_i  (k < int'(n_q)),
        .dly_i (dly_q[DW*k +: DW]),
        .wid_i (wid_q[DW*k +: DW]),
        .gdly_i(gdly_q),
        .gwid_i(gwid_q),
        .hit_o (hit[k]),
        .end_o (ends[k])
      );
    end
  endgenerate

  assign arm = |arm_bits;

  always_comb begin
    last = '0;
    for (int i = 0; i < NSLOT; i++)
      if (ends[i] > last) last = ends[i];
  end

  tpg_seq #(.CW(CW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .arm_i   (arm),
    .last_i  (last),
    .accept_o(accept),
    .busy_o  (busy),
    .cnt_o   (cnt)
  );

  // configuration captured at acceptance only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q    <= '0;
      gdly_q <= '0;
      gwid_q <= '0;
      dly_q  <= '0;
      wid_q  <= '0;
    end else if (accept) begin
      n_q    <= slot_count(mode_i);
      gdly_q <= gdly_i;
      gwid_q <= gwid_i;
      dly_q  <= dly_i;
      wid_q  <= wid_i;
    end
  end

  assign busy_o  = busy;
  assign pulse_o = (busy && |hit) ^ pol_i;

  // R8
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (pulse_o == pol_i));

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(dly_q) && $stable(wid_q) && $stable(n_q)
                                   && $stable(gdly_q) && $stable(gwid_q)));

  // R4
  off_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && slot_count(mode_i) == 2'd0) |=> !busy_o);

  // R5
  no_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && wid_i == '0) |=> !busy_o);
endmodule

// File: tb/tpg_top_bench.sv
`timescale 1ns/1ps
module tpg_top_bench;
  localparam int DW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] mode = '0;
  logic pol = 1'b0;
  logic [DW-1:0] gdly = '0, gwid = '0;
  logic [3*DW-1:0] dly = '0, wid = '0;
  logic pulse, busy;

  int n_chk = 0, n_bad = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  tpg_top #(.DW(DW)) u_tpg_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .pol_i(pol),
    .gdly_i(gdly), .gwid_i(gwid), .dly_i(dly), .wid_i(wid),
    .pulse_o(pulse), .busy_o(busy));

  // reference model built from the requirements
  bit m_busy, m_sq;
  longint m_t;
  int m_n;
  longint m_d[3], m_w[3], m_g, m_gw;

  function automatic int cnt_of(logic [2:0] md);
    return (md >= 3'd1 && md <= 3'd3) ? int'(md) : 0;
  endfunction

  function automatic bit m_hit(longint t);
    bit h = 0;
    for (int k = 0; k < m_n; k++)
      if (m_w[k] != 0 && t >= m_g + m_d[k] && t < m_g + m_d[k] + m_w[k] + m_gw) h = 1;
    return h;
  endfunction

  function automatic longint m_last();
    longint l = 0;
    for (int k = 0; k < m_n; k++)
      if (m_w[k] != 0 && m_g + m_d[k] + m_w[k] + m_gw > l) l = m_g + m_d[k] + m_w[k] + m_gw;
    return l;
  endfunction

  function automatic bit in_arm();
    bit a = 0;
    for (int k = 0; k < cnt_of(mode); k++)
      if (wid[DW*k +: DW] != 0) a = 1;
    return a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_sq = 0; m_t = 0; m_n = 0;
    end else begin
      if (start && !m_sq && !m_busy && in_arm()) begin
        m_busy = 1; m_t = 0; m_n = cnt_of(mode);
        m_g = gdly; m_gw = gwid;
        for (int k = 0; k < 3; k++) begin
          m_d[k] = dly[DW*k +: DW];
          m_w[k] = wid[DW*k +: DW];
        end
      end else if (m_busy) begin
        if (m_t == m_last() - 1) m_busy = 0;
        else m_t++;
      end
      m_sq = start;
    end
  end

  task automatic cmp(string req, string what, logic a, logic e);
    n_chk++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, a, e, $time);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmp(tag, "busy", busy, m_busy);
      cmp((m_busy ? tag : "R8"), "pulse", pulse, (m_busy && m_hit(m_t)) ^ pol);
    end
  endtask

  task automatic cfg(logic [2:0] md, logic p, int g, int gw,
                     int d0, int d1, int d2, int w0, int w1, int w2);
    mode = md; pol = p; gdly = DW'(g); gwid = DW'(gw);
    dly = {DW'(d2), DW'(d1), DW'(d0)};
    wid = {DW'(w2), DW'(w1), DW'(w0)};
  endtask

  task automatic fire();
    start = 1'b1; step(1); start = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1 reset state
    tag = "R1";
    step(3);
    @(negedge clk); rst_n = 1'b1;
    step(2);
    pol = 1'b1; step(1); cmp("R1", "idle pulse", pulse, 1'b1); pol = 1'b0;

    // R2 one-clock pulse right after acceptance
    tag = "R2";
    cfg(3'd1, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    cmp("R2", "t0 pulse", pulse, 1'b1);
    cmp("R2", "t0 busy", busy, 1'b1);
    step(1); cmp("R2", "t1 pulse", pulse, 1'b0);
    step(3);

    // R3 three separate pulses at 5/15/30
    tag = "R3";
    cfg(3'd3, 0, 0, 0, 5, 15, 30, 5, 6, 7);
    fire(); step(45);
    // R3 with group delay and width
    cfg(3'd3, 0, 4, 2, 0, 10, 20, 3, 3, 3);
    fire(); step(35);

    // R4 mode limits
    tag = "R4";
    cfg(3'd2, 0, 0, 0, 2, 6, 10, 2, 2, 2);
    fire(); step(16);
    for (int md = 0; md < 8; md++) begin
      if (md >= 1 && md <= 3) continue;
      cfg(3'(md), 0, 0, 0, 0, 0, 0, 1, 1, 1);
      fire(); step(3);
      cmp("R4", "disabled busy", busy, 1'b0);
    end

    // R5 zero width
    tag = "R5";
    cfg(3'd3, 0, 0, 0, 1, 4, 8, 2, 0, 2);
    fire(); step(14);
    cfg(3'd2, 0, 0, 0, 1, 4, 8, 0, 0, 5);
    fire(); step(3);
    cmp("R5", "no-slot busy", busy, 1'b0);

    // R6 retrigger ignored, also in last busy cycle
    tag = "R6";
    cfg(3'd1, 0, 0, 0, 3, 0, 0, 4, 0, 0);
    fire(); step(2); fire(); step(1); fire(); step(1);
    fire(); step(6);

    // R7 busy length
    tag = "R7";
    cfg(3'd3, 0, 0, 0, 20, 2, 9, 1, 3, 1);
    fire(); step(21);
    cmp("R7", "busy end", busy, 1'b0);
    step(2);

    // R8 inverted output
    tag = "R8";
    cfg(3'd2, 1, 1, 0, 0, 4, 0, 2, 2, 0);
    fire(); step(10);

    // R9 config change mid-sequence
    tag = "R9";
    cfg(3'd3, 0, 0, 0, 2, 8, 14, 3, 3, 3);
    fire(); step(3);
    cfg(3'd1, 0, 7, 9, 0, 0, 0, 1, 1, 1);
    step(20);

    // R10 held start
    tag = "R10";
    cfg(3'd1, 0, 0, 0, 1, 0, 0, 1, 0, 0);
    start = 1'b1; step(12);
    cmp("R10", "held busy", busy, 1'b0);
    start = 1'b0; step(2);

    // random mix
    tag = "R3";
    for (int c = 0; c < 8000; c++) begin
      if ($urandom_range(0, 7) == 0)
        cfg(3'($urandom_range(0, 7)), $urandom_range(0, 1) != 0,
            $urandom_range(0, 6), $urandom_range(0, 3),
            $urandom_range(0, 30), $urandom_range(0, 30), $urandom_range(0, 30),
            $urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6));
      start = ($urandom_range(0, 3) == 0);
      step(1);
    end
    start = 1'b0;
    step(120);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule